// File: doc/BRIEF.md
# Mode-Selectable Addressable Bit Latch

This block is a small parallel storage register in which exactly one bit is updated per cycle, picked by a binary address. A single serial data input, an active-low write enable and an active-high clear are combined into four operating modes. With both controls inactive-low, the addressed bit takes the data value and the rest keep their contents. Raising the enable freezes every bit. Raising the clear while writing turns the block into a one-of-N demultiplexer: the addressed bit carries the data and all the other bits are forced to zero. Raising both wipes the whole register.

The block runs from a system clock. The control, address and data inputs are captured in a register stage on one rising edge, and the storage takes the new value on the next one. Typical uses are serial-to-parallel conversion, random bit writes into a control word, and routing a strobe to one of several outputs.

An optional monitor raises a one-cycle flag when the address changes in more than one bit between consecutive cycles while writing is enabled. Such a change can briefly select the wrong bit, so the address should only change that way while the register is frozen.

Top module: `addressable_latch`

## Requirements
- R1: While the reset input is low, and until inputs reach the storage after its release, all output bits and the skew flag read 0.
- R2: Latch mode (enable input = 0, clear input = 0): the addressed bit takes the data value and every other bit keeps its previous value.
- R3: Memory mode (enable input = 1, clear input = 0): all bits keep their values. The value written in the last enabled cycle before the enable rises is the one that is held.
- R4: Demultiplexer mode (enable input = 0, clear input = 1): the addressed bit takes the data value and every other bit becomes 0.
- R5: Clear mode (enable input = 1, clear input = 1): all output bits become 0.
- R6: An address value k selects output bit q[k], with bit 0 the least significant output bit.
- R7: Inputs applied before rising edge n are captured at edge n and reach the outputs at edge n+1. The outputs do not change at edge n in response to them.
- R8: With the skew monitor enabled, the flag is 1 for exactly the cycle after the storage update that follows a captured input cycle in which the enable was 0 and the address differed from the previously captured address in two or more bits. It is 0 otherwise. With the monitor disabled, the flag is always 0.
- R9: After a demultiplexer-mode write followed by memory mode, the register holds the written data in the addressed bit and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_n | input | 1 | Active-low write enable |
| clr | input | 1 | Active-high clear / demultiplex select |
| addr | input | ADDR_W | Bit address |
| din | input | 1 | Serial data input |
| q | output | 2**ADDR_W | Parallel stored bits |
| addr_skew | output | 1 | Multi-bit address change seen while enabled (optional) |

## Verification
The bench builds the block at its default size, an address of three bits giving eight outputs, with the skew monitor on. The address is therefore small enough that random stimulus hits every address under every mode many times, and random address steps often differ in two or more bits during enabled cycles, which exercises the flag. Directed sequences cover a sweep of all addresses, the two-edge latency, the value held after the enable rises, and the state left behind by demultiplexing.

// File: rtl/adl_pkg.sv
package adl_pkg;

  typedef enum logic [1:0] {
    MODE_LATCH  = 2'b00,
    MODE_DEMUX  = 2'b01,
    MODE_MEMORY = 2'b10,
    MODE_CLEAR  = 2'b11
  } adl_mode_e;

  // Mode is {enable_n, clear}.
  function automatic adl_mode_e adl_mode(input logic en_n, input logic clr);
    return adl_mode_e'({en_n, clr});
  endfunction

endpackage

// File: rtl/adl_rst_sync.sv
module adl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/adl_in_stage.sv
module adl_in_stage #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              en_n_o,
  output logic              clr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              din_o
);

  // Reset state equals memory mode with address 0, so nothing is written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_n_o <= 1'b1;
      clr_o  <= 1'b0;
      addr_o <= '0;
      din_o  <= 1'b0;
    end else begin
      en_n_o <= en_n_i;
      clr_o  <= clr_i;
      addr_o <= addr_i;
      din_o  <= din_i;
    end
  end

endmodule

// File: rtl/adl_addr_decode.sv
module adl_addr_decode #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  sel
);

  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/adl_bit_array.sv
module adl_bit_array #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  adl_pkg::adl_mode_e   mode,
  input  logic [NBITS-1:0]     sel,
  input  logic                 din,
  output logic [NBITS-1:0]     q
);
  import adl_pkg::*;

  logic [NBITS-1:0] q_nxt;
  logic             upd;

  // Memory mode is the only mode that leaves every bit alone.
  assign upd = (mode != MODE_MEMORY);

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    always_comb begin
      unique case (mode)
        MODE_LATCH:  q_nxt[i] = sel[i] ? din : q[i];
        MODE_DEMUX:  q_nxt[i] = sel[i] & din;
        MODE_CLEAR:  q_nxt[i] = 1'b0;
        default:     q_nxt[i] = q[i];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[i] <= 1'b0;
      else if (upd) q[i] <= q_nxt[i];
    end
  end

endmodule

// File: rtl/adl_skew_mon.sv
module adl_skew_mon #(
  parameter int ADDR_W = 3,
  parameter bit ENABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              flag
);

  if (ENABLE) begin : g_on
    logic [ADDR_W-1:0] prev_q;
    logic [ADDR_W-1:0] diff;
    logic              multi;
    logic              flag_nxt;

    always_comb begin
      diff     = addr ^ prev_q;
      // More than one bit set: clearing the lowest set bit leaves something.
      multi    = |(diff & (diff - ADDR_W'(1)));
      flag_nxt = !en_n && multi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '0;
        flag   <= 1'b0;
      end else begin
        prev_q <= addr;
        flag   <= flag_nxt;
      end
    end
  end else begin : g_off
    logic unused;
    assign unused = &{1'b0, clk, rst_n, en_n, addr};
    assign flag   = 1'b0;
  end

endmodule

// File: rtl/addressable_latch.sv
module addressable_latch #(
  parameter int ADDR_W     = 3,
  parameter bit SKEW_CHECK = 1'b1,
  localparam int NBITS     = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [NBITS-1:0]  q,
  output logic              addr_skew
);
  import adl_pkg::*;

  logic              rst_core_n;
  logic              en_n_q;
  logic              clr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              din_q;
  logic [NBITS-1:0]  sel;
  adl_mode_e         mode;

  adl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  adl_in_stage #(.ADDR_W(ADDR_W)) u_in (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .en_n_i (wr_en_n),
    .clr_i  (clr),
    .addr_i (addr),
    .din_i  (din),
    .en_n_o (en_n_q),
    .clr_o  (clr_q),
    .addr_o (addr_q),
    .din_o  (din_q)
  );

  assign mode = adl_mode(en_n_q, clr_q);

  adl_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr_q),
    .sel  (sel)
  );

  adl_bit_array #(.ADDR_W(ADDR_W)) u_bits (
    .clk   (clk),
    .rst_n (rst_core_n),
    .mode  (mode),
    .sel   (sel),
    .din   (din_q),
    .q     (q)
  );

  adl_skew_mon #(.ADDR_W(ADDR_W), .ENABLE(SKEW_CHECK)) u_skew (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en_n  (en_n_q),
    .addr  (addr_q),
    .flag  (addr_skew)
  );

endmodule

// File: rtl/adl_checker.sv
module adl_checker #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              en_n_q,
  input logic              clr_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              din_q,
  input logic [NBITS-1:0]  q,
  input logic              addr_skew
);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en_n_q && clr_q) |=> (q == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en_n_q && !clr_q) |=> (q == $past(q)));

  p_addressed_bit_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!en_n_q) |=> (q[$past(addr_q)] == $past(din_q)));

  p_latch_one_change_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!en_n_q && !clr_q) |=> ($countones(q ^ $past(q)) <= 1));

  p_demux_onehot_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!en_n_q && clr_q) |=> $onehot0(q));

  p_skew_enabled_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    addr_skew |-> $past(!en_n_q));

endmodule

bind addressable_latch adl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .en_n_q     (en_n_q),
  .clr_q      (clr_q),
  .addr_q     (addr_q),
  .din_q      (din_q),
  .q          (q),
  .addr_skew  (addr_skew)
);

// File: tb/addressable_latch_bench.sv
`timescale 1ns/1ps
module addressable_latch_bench;

  localparam int ADDR_W = 3;
  localparam int NBITS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en_n;
  logic              clr;
  logic [ADDR_W-1:0] addr;
  logic              din;
  logic [NBITS-1:0]  q;
  logic              addr_skew;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference state: captured-input stage, previous captured address, storage.
  logic              st_en_n, st_clr, st_d;
  logic [ADDR_W-1:0] st_addr, prev_addr;
  logic [NBITS-1:0]  ref_q;
  logic              ref_flag;

  always #2.5 clk = ~clk;

  addressable_latch #(.ADDR_W(ADDR_W), .SKEW_CHECK(1'b1)) u_addressable_latch (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .clr(clr),
    .addr(addr), .din(din), .q(q), .addr_skew(addr_skew)
  );

  function automatic logic [NBITS-1:0] model_q(input logic [NBITS-1:0] cur,
      input logic en_n, input logic c, input logic [ADDR_W-1:0] a, input logic d);
    logic [NBITS-1:0] r;
    r = cur;
    case ({en_n, c})
      2'b00: r[a] = d;
      2'b01: begin r = '0; r[a] = d; end
      2'b10: r = cur;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic model_flag(input logic en_n,
      input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] p);
    return !en_n && ($countones(a ^ p) > 1);
  endfunction

  function automatic string mode_tag(input logic en_n, input logic c);
    case ({en_n, c})
      2'b00: return "R2";
      2'b01: return "R4";
      2'b10: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic chk_q(input string tag, input logic [NBITS-1:0] exp);
    n_checks++;
    if (q !== exp) begin
      n_fail++;
      $display("FAIL %s: q actual=%b expected=%b", tag, q, exp);
    end
  endtask

  task automatic chk_flag(input string tag, input logic exp);
    n_checks++;
    if (addr_skew !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_skew actual=%b expected=%b", tag, addr_skew, exp);
    end
  endtask

  // One cycle: the posedge before this negedge applied the model step.
  task automatic step(input logic e, input logic c, input logic [ADDR_W-1:0] a,
                      input logic d, input string tag);
    string t;
    @(negedge clk);
    ref_flag  = model_flag(st_en_n, st_addr, prev_addr);
    t         = (tag == "") ? mode_tag(st_en_n, st_clr) : tag;
    ref_q     = model_q(ref_q, st_en_n, st_clr, st_addr, st_d);
    prev_addr = st_addr;
    st_en_n = wr_en_n; st_clr = clr; st_addr = addr; st_d = din;
    chk_q(t, ref_q);
    chk_flag("R8", ref_flag);
    wr_en_n = e; clr = c; addr = a; din = d;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [NBITS-1:0] snap;
    void'($urandom(32'd4099));
    rst_n = 1'b0; wr_en_n = 1'b1; clr = 1'b0; addr = '0; din = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_q("R1", '0);
    chk_flag("R1", 1'b0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    st_en_n = 1'b1; st_clr = 1'b0; st_addr = '0; st_d = 1'b0;
    prev_addr = '0; ref_q = '0;
    @(negedge clk);
    chk_q("R1", '0);

    // R7: latch write to bit 5 must not show after the first edge.
    wr_en_n = 1'b0; clr = 1'b0; addr = 3'd5; din = 1'b1;
    step(1'b1, 1'b0, 3'd5, 1'b1, "R7");
    if (q !== '0) begin n_fail++; $display("FAIL R7: q actual=%b expected=%b", q, '0); end
    n_checks++;
    step(1'b1, 1'b0, 3'd5, 1'b1, "R7");
    if (q !== 8'b0010_0000) begin
      n_fail++; $display("FAIL R7: q actual=%b expected=%b", q, 8'b0010_0000);
    end
    n_checks++;

    // R6: address sweep in latch mode, write 1 to every bit in turn.
    for (int k = 0; k < NBITS; k++) step(1'b0, 1'b0, ADDR_W'(k), 1'b1, "R6");
    step(1'b1, 1'b0, '0, 1'b0, "R6");
    step(1'b1, 1'b0, '0, 1'b0, "R6");
    chk_q("R6", '1);

    // R3: value of last enabled cycle held, later data/address ignored.
    step(1'b0, 1'b0, 3'd2, 1'b0, "R3");
    step(1'b1, 1'b0, 3'd2, 1'b0, "R3");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, ADDR_W'(k), k[0], "R3");
    chk_q("R3", 8'b1111_1011);

    // R5: clear, then R4/R9: demux write of 1 to bit 6, then hold.
    step(1'b1, 1'b1, 3'd0, 1'b1, "R5");
    step(1'b0, 1'b1, 3'd6, 1'b1, "R5");
    step(1'b1, 1'b0, 3'd6, 1'b0, "R4");
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, ADDR_W'(k), 1'b1, "R9");
    chk_q("R9", 8'b0100_0000);

    // R8: two-bit address change while enabled, then single-bit change.
    step(1'b0, 1'b0, 3'd0, 1'b0, "R8");
    step(1'b0, 1'b0, 3'd3, 1'b0, "R8");
    step(1'b0, 1'b0, 3'd2, 1'b0, "R8");
    step(1'b1, 1'b0, 3'd5, 1'b0, "R8");
    step(1'b1, 1'b0, 3'd5, 1'b0, "R8");
    step(1'b1, 1'b0, 3'd5, 1'b0, "R8");

    // Random stimulus over all modes and addresses.
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      step(r < 4'd6 ? 1'b0 : 1'b1,
           (r == 4'd3 || r == 4'd15) ? 1'b1 : 1'b0,
           ADDR_W'($urandom), 1'($urandom), "");
    end
    repeat (2) step(1'b1, 1'b0, '0, 1'b0, "");
    snap = ref_q;
    chk_q("R3", snap);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule